// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Controller

This block produces the port-to-port interrupts of a shared two-port memory. The two topmost words of the address space are mailboxes. The top word belongs to the right port, and the word just below it belongs to the left port. When one port writes the other port's mailbox, the owner's interrupt is raised. The owner acknowledges the interrupt by reading its own mailbox. A busy input on each port marks an access that lost arbitration. Such an access can neither raise nor acknowledge an interrupt.

Each interrupt flag is a two-state machine:

- `FLAG_IDLE` means the interrupt is not pending, so the output is high.
- `FLAG_PEND` means the interrupt is pending, so the output is low.

The machine takes one of three transitions on every clock:

- **raise**: it moves to `FLAG_PEND` when a set is present, from either state.
- **acknowledge**: it moves from `FLAG_PEND` to `FLAG_IDLE` when a clear is present and no set is present.
- **hold**: it keeps its state when neither is present.

A small register model holds the two mailbox words so that reads return the stored messages. All other addresses are outside the block, and reads of them return zero.

Accesses are synchronous. A request is sampled at a rising clock edge, and the interrupt outputs and read data change right after that same edge.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, both interrupt outputs are high (1), both read-data outputs are zero, and both stored mailbox words are zero.
- R2: A non-busy write by the left port to the all-ones address drives `rp_irq_n` low after the next clock edge.
- R3: A non-busy write by the right port to the all-ones-minus-one address drives `lp_irq_n` low after the next clock edge.
- R4: A non-busy read by a port of its own mailbox returns that port's interrupt output to high after the next edge. The left port owns all-ones-minus-one and the right port owns all-ones.
- R5: A read of the other port's mailbox leaves both interrupt outputs unchanged.
- R6: A write with the writer's busy input high neither raises an interrupt nor changes a stored mailbox word.
- R7: A read of a port's own mailbox with that port's busy input high leaves its interrupt low.
- R8: When a set and an acknowledge for the same flag occur in one cycle, the flag ends pending (output low).
- R9: Writes to addresses other than the two mailboxes, and a port's write to its own mailbox, do not change either interrupt output.
- R10: A read request returns, one edge later, the mailbox word at that address as it stood before that edge, or zero for any other address. With no read request, the read data is zero. A port's busy input does not affect its read data.
- R11: If both ports write the same mailbox word without busy in one cycle, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lp_req | input | 1 | Left port access request |
| lp_we | input | 1 | Left port write (1) or read (0) |
| lp_addr | input | AW | Left port address |
| lp_wdata | input | DW | Left port write data |
| lp_busy | input | 1 | Left port lost arbitration this cycle |
| lp_rdata | output | DW | Left port read data, registered |
| lp_irq_n | output | 1 | Left port interrupt, active low |
| rp_req | input | 1 | Right port access request |
| rp_we | input | 1 | Right port write (1) or read (0) |
| rp_addr | input | AW | Right port address |
| rp_wdata | input | DW | Right port write data |
| rp_busy | input | 1 | Right port lost arbitration this cycle |
| rp_rdata | output | DW | Right port read data, registered |
| rp_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The hardest case to reach is the collision of a raise and an acknowledge on the same flag in one cycle. This needs the owner reading its own mailbox in exactly the cycle the other port writes it, with neither port busy. The directed stimulus builds this collision explicitly and drives both ports on the same edge. It then checks that the flag stays pending and that the read returns the word held before the write. A stretch of random two-port traffic over the two mailbox addresses and one ordinary address follows, with random busy bits. This traffic produces further collisions, blocked writes and blocked acknowledges, and each is compared against a behavioural model every cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Interrupt flag state: IDLE = not pending (output high), PEND = pending (output low)
    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_t;

    // Per-port decoded access events
    typedef struct packed {
        logic set_other;   // raise the other side's flag
        logic clr_own;     // acknowledge own flag
        logic wr_top;      // store into the all-ones word
        logic wr_sub;      // store into the all-ones-minus-one word
        logic rd_top;      // read of the all-ones word
        logic rd_sub;      // read of the all-ones-minus-one word
        logic rd_any;      // any read request
    } port_evt_t;

    localparam int NSIDE = 2;  // 0 = left, 1 = right

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int AW     = 8,
    parameter bit OWN_HI = 1'b0   // 1: this port owns the all-ones word
) (
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic          busy,
    output port_evt_t     evt
);

    localparam logic [AW-1:0] ADDR_TOP   = {AW{1'b1}};
    localparam logic [AW-1:0] ADDR_SUB   = ADDR_TOP - 1'b1;
    localparam logic [AW-1:0] ADDR_OWN   = OWN_HI ? ADDR_TOP : ADDR_SUB;
    localparam logic [AW-1:0] ADDR_OTHER = OWN_HI ? ADDR_SUB : ADDR_TOP;

    logic is_wr, is_rd;

    always_comb begin
        is_wr         = req && we;
        is_rd         = req && !we;
        evt.set_other = is_wr && !busy && (addr == ADDR_OTHER);
        evt.clr_own   = is_rd && !busy && (addr == ADDR_OWN);
        evt.wr_top    = is_wr && !busy && (addr == ADDR_TOP);
        evt.wr_sub    = is_wr && !busy && (addr == ADDR_SUB);
        evt.rd_top    = is_rd && (addr == ADDR_TOP);
        evt.rd_sub    = is_rd && (addr == ADDR_SUB);
        evt.rd_any    = is_rd;
    end

endmodule

// File: rtl/mbx_flag_fsm.sv
module mbx_flag_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n
);

    flag_state_t state, state_nx;

    // next-state
    always_comb begin
        state_nx = state;
        unique case (state)
            FLAG_IDLE: if (set_i) state_nx = FLAG_PEND;                  // raise
            FLAG_PEND: if (clr_i && !set_i) state_nx = FLAG_IDLE;        // acknowledge
            default:   state_nx = FLAG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FLAG_IDLE;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        unique case (state)
            FLAG_PEND: irq_n = 1'b0;
            default:   irq_n = 1'b1;
        endcase
    end

    // R8: a set in the same cycle as a clear leaves the flag pending
    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> (irq_n == 1'b0));

    // R4: a lone clear ends with the output high
    a_r4_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> (irq_n == 1'b1));

    // R5: no event, no change
    a_r5_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(irq_n));

endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  port_evt_t            evt   [NSIDE],
    input  logic [DW-1:0]        wdata [NSIDE],
    output logic [DW-1:0]        rdata [NSIDE]
);

    logic [DW-1:0] word_top, word_sub;

    // storage: left port (side 0) has priority on a same-word collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_top <= '0;
            word_sub <= '0;
        end else begin
            if (evt[0].wr_top)      word_top <= wdata[0];
            else if (evt[1].wr_top) word_top <= wdata[1];
            if (evt[0].wr_sub)      word_sub <= wdata[0];
            else if (evt[1].wr_sub) word_sub <= wdata[1];
        end
    end

    // registered read paths, one per side
    for (genvar s = 0; s < NSIDE; s++) begin : g_rd
        always_ff @(posedge clk) begin
            if (!rst_n)             rdata[s] <= '0;
            else if (evt[s].rd_top) rdata[s] <= word_top;
            else if (evt[s].rd_sub) rdata[s] <= word_sub;
            else                    rdata[s] <= '0;
        end

        // R10: a read of neither mailbox word returns zero
        a_r10_plain_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt[s].rd_top && !evt[s].rd_sub) |=> (rdata[s] == '0));
    end

    // R11: on a same-word collision the left data is kept
    a_r11_left_wins_top: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[0].wr_top && evt[1].wr_top) |=> (word_top == $past(wdata[0])));

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lp_req,
    input  logic          lp_we,
    input  logic [AW-1:0] lp_addr,
    input  logic [DW-1:0] lp_wdata,
    input  logic          lp_busy,
    output logic [DW-1:0] lp_rdata,
    output logic          lp_irq_n,
    input  logic          rp_req,
    input  logic          rp_we,
    input  logic [AW-1:0] rp_addr,
    input  logic [DW-1:0] rp_wdata,
    input  logic          rp_busy,
    output logic [DW-1:0] rp_rdata,
    output logic          rp_irq_n
);

    localparam logic [AW-1:0] ADDR_TOP = {AW{1'b1}};
    localparam logic [AW-1:0] ADDR_SUB = ADDR_TOP - 1'b1;

    logic          req_a  [NSIDE];
    logic          we_a   [NSIDE];
    logic [AW-1:0] addr_a [NSIDE];
    logic          busy_a [NSIDE];
    logic [DW-1:0] wd_a   [NSIDE];
    logic [DW-1:0] rd_a   [NSIDE];
    logic          irq_a  [NSIDE];
    port_evt_t     evt    [NSIDE];

    always_comb begin
        req_a[0] = lp_req;   req_a[1] = rp_req;
        we_a[0]  = lp_we;    we_a[1]  = rp_we;
        addr_a[0] = lp_addr; addr_a[1] = rp_addr;
        busy_a[0] = lp_busy; busy_a[1] = rp_busy;
        wd_a[0]  = lp_wdata; wd_a[1]  = rp_wdata;
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        mbx_port_decode #(.AW(AW), .OWN_HI(s == 1)) u_dec (
            .req  (req_a[s]),
            .we   (we_a[s]),
            .addr (addr_a[s]),
            .busy (busy_a[s]),
            .evt  (evt[s])
        );

        // flag of side s is raised by the opposite side, acknowledged by itself
        mbx_flag_fsm u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt[NSIDE-1-s].set_other),
            .clr_i (evt[s].clr_own),
            .irq_n (irq_a[s])
        );
    end

    mbx_store #(.DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .wdata (wd_a),
        .rdata (rd_a)
    );

    assign lp_rdata = rd_a[0];
    assign rp_rdata = rd_a[1];
    assign lp_irq_n = irq_a[0];
    assign rp_irq_n = irq_a[1];

    // R2: left write to the all-ones word raises the right interrupt
    a_r2_left_write_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_req && lp_we && !lp_busy && lp_addr == ADDR_TOP) |=> !rp_irq_n);

    // R3: right write to the word below raises the left interrupt
    a_r3_right_write_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_req && rp_we && !rp_busy && rp_addr == ADDR_SUB) |=> !lp_irq_n);

    // R6: a busy left write cannot raise an idle right interrupt
    a_r6_busy_blocks_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_irq_n && lp_req && lp_we && lp_busy) |=> rp_irq_n);

    // R7: a busy left read of its own word cannot acknowledge
    a_r7_busy_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_irq_n && lp_req && !lp_we && lp_busy && lp_addr == ADDR_SUB) |=> !lp_irq_n);

endmodule

// File: tb/test_mbx_irq_ctrl.sv
module test_mbx_irq_ctrl;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int CLK_PERIOD = 10;
    localparam logic [AW-1:0] TOP = {AW{1'b1}};
    localparam logic [AW-1:0] SUB = TOP - 1'b1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lp_req = 0, lp_we = 0, lp_busy = 0;
    logic [AW-1:0] lp_addr = '0;
    logic [DW-1:0] lp_wdata = '0;
    logic          rp_req = 0, rp_we = 0, rp_busy = 0;
    logic [AW-1:0] rp_addr = '0;
    logic [DW-1:0] rp_wdata = '0;
    logic [DW-1:0] lp_rdata, rp_rdata;
    logic          lp_irq_n, rp_irq_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference state
    bit         m_lirq = 0, m_rirq = 0;       // 1 = pending
    int         m_word[logic [AW-1:0]];       // mailbox contents
    int         m_lrd = 0, m_rrd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_irq_ctrl #(.AW(AW), .DW(DW)) i_mbx_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .lp_req(lp_req), .lp_we(lp_we), .lp_addr(lp_addr), .lp_wdata(lp_wdata),
        .lp_busy(lp_busy), .lp_rdata(lp_rdata), .lp_irq_n(lp_irq_n),
        .rp_req(rp_req), .rp_we(rp_we), .rp_addr(rp_addr), .rp_wdata(rp_wdata),
        .rp_busy(rp_busy), .rp_rdata(rp_rdata), .rp_irq_n(rp_irq_n)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int rd_val(input bit req, input bit we, input logic [AW-1:0] a);
        if (!req || we) return 0;
        if (a == TOP || a == SUB) return m_word[a];
        return 0;
    endfunction

    // one clock: apply inputs at negedge, update model, compare at next negedge
    task automatic cyc(input bit lr, input bit lw, input logic [AW-1:0] la, input int ld, input bit lb,
                       input bit rr, input bit rw, input logic [AW-1:0] ra, input int rd, input bit rb,
                       input string tag);
        bit l_set_r, r_set_l, l_clr, r_clr;
        lp_req = lr; lp_we = lw; lp_addr = la; lp_wdata = DW'(ld); lp_busy = lb;
        rp_req = rr; rp_we = rw; rp_addr = ra; rp_wdata = DW'(rd); rp_busy = rb;
        l_set_r = lr && lw && !lb && la == TOP;
        r_set_l = rr && rw && !rb && ra == SUB;
        l_clr   = lr && !lw && !lb && la == SUB;
        r_clr   = rr && !rw && !rb && ra == TOP;
        m_lrd = rd_val(lr, lw, la);
        m_rrd = rd_val(rr, rw, ra);
        if (r_set_l) m_lirq = 1; else if (l_clr) m_lirq = 0;
        if (l_set_r) m_rirq = 1; else if (r_clr) m_rirq = 0;
        if (rr && rw && !rb && (ra == TOP || ra == SUB)) m_word[ra] = rd & ((1 << DW) - 1);
        if (lr && lw && !lb && (la == TOP || la == SUB)) m_word[la] = ld & ((1 << DW) - 1);
        @(posedge clk);
        @(negedge clk);
        chk(tag, "lp_irq_n", int'(lp_irq_n), int'(!m_lirq));
        chk(tag, "rp_irq_n", int'(rp_irq_n), int'(!m_rirq));
        chk(tag, "lp_rdata", int'(lp_rdata), m_lrd);
        chk(tag, "rp_rdata", int'(rp_rdata), m_rrd);
    endtask

    task automatic idle(input string tag);
        cyc(0,0,'0,0,0, 0,0,'0,0,0, tag);
    endtask

    initial begin
        m_word[TOP] = 0;
        m_word[SUB] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        chk("R1", "lp_irq_n in reset", int'(lp_irq_n), 1);
        chk("R1", "rp_irq_n in reset", int'(rp_irq_n), 1);
        chk("R1", "lp_rdata in reset", int'(lp_rdata), 0);
        rst_n = 1'b1;
        idle("R1");
        // R1: stored words start at zero
        cyc(1,0,TOP,0,0, 1,0,SUB,0,0, "R1");

        // R2: left writes the right mailbox
        cyc(1,1,TOP,8'hA5,0, 0,0,'0,0,0, "R2");
        // R5 and R10: left reads the right mailbox, nothing changes
        cyc(1,0,TOP,0,0, 0,0,'0,0,0, "R5");
        // R7: busy right read of own word keeps the interrupt
        cyc(0,0,'0,0,0, 1,0,TOP,0,1, "R7");
        // R4: right acknowledges by reading its own mailbox
        cyc(0,0,'0,0,0, 1,0,TOP,0,0, "R4");
        // R6: busy right write to the left mailbox does nothing
        cyc(0,0,'0,0,0, 1,1,SUB,8'h3C,1, "R6");
        cyc(1,0,TOP,0,0, 1,0,SUB,0,0, "R6");
        // R3: right writes the left mailbox
        cyc(0,0,'0,0,0, 1,1,SUB,8'h3C,0, "R3");
        // R5: right reads the left mailbox
        cyc(0,0,'0,0,0, 1,0,SUB,0,0, "R5");
        // R9: ordinary write and owner's write to its own word
        cyc(1,1,8'h10,8'h77,0, 1,1,TOP,8'h99,0, "R9");
        cyc(1,1,SUB,8'h11,0, 0,0,'0,0,0, "R9");
        // R8: left acknowledge collides with a right raise
        cyc(1,0,SUB,0,0, 1,1,SUB,8'h42,0, "R8");
        idle("R8");
        // R4: left acknowledges
        cyc(1,0,SUB,0,0, 0,0,'0,0,0, "R4");
        // R11: both write the all-ones word
        cyc(1,1,TOP,8'h5A,0, 1,1,TOP,8'hC3,0, "R11");
        cyc(0,0,'0,0,0, 1,0,TOP,0,0, "R11");
        // R10: ordinary-address reads return zero, busy does not gate read data
        cyc(1,0,8'h20,0,0, 1,0,SUB,0,1, "R10");

        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] la, ra;
            int sel;
            sel = $urandom_range(0, 2);
            la = (sel == 0) ? TOP : (sel == 1) ? SUB : 8'h05;
            sel = $urandom_range(0, 2);
            ra = (sel == 0) ? TOP : (sel == 1) ? SUB : 8'h05;
            cyc($urandom_range(0,1), $urandom_range(0,1), la, $urandom_range(0,255),
                ($urandom_range(0,3) == 0),
                $urandom_range(0,1), $urandom_range(0,1), ra, $urandom_range(0,255),
                ($urandom_range(0,3) == 0), "R2/R3/R4/R8/R10 random");
        end

        // R1: reset in mid-operation clears everything
        cyc(1,1,TOP,8'h01,0, 1,1,SUB,8'h02,0, "R1");
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_lirq = 0; m_rirq = 0; m_word[TOP] = 0; m_word[SUB] = 0;
        cyc(1,0,TOP,0,0, 1,0,SUB,0,0, "R1");

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule